// File: doc/BRIEF.md
# Microcontroller Clock Control Unit

This block turns a fast main oscillator and a slow sub-oscillator into the clock enables of a small microcontroller. Every output is a one-cycle enable pulse in the fast clock domain. The outputs are:

- the CPU bus clock enable;
- three peripheral enables, running at the main clock rate, one eighth of it and one thirty-second of it;
- the sub-clock enable;
- the sub-clock divided by 32.

Software steers the block through two 8-bit control registers. They choose the CPU clock source and its divide ratio, stop the main clock, start the sub-oscillator, gate the peripheral clocks during a wait instruction, and set the drive strength of both oscillators.

Two event inputs, stop mode and wait mode, act on the block alongside software:

- **Stop mode:** entering it rewrites some control bits on its own. Which bits change depends on whether the CPU was running from the main clock or from the sub-clock. While stop mode lasts, every enable is held low.
- **Wait mode:** the peripheral enables stop only when software has armed that gating.

A change of CPU clock source or divide ratio is held back until the next CPU clock pulse, so the bus clock never produces a shortened period.

The sub-oscillator input is asynchronous. It passes through a two-flop synchroniser, and its rising edge is detected to form the sub-clock enable.

Top module: `clkCtrlUnit`

## Requirements

- R1: After reset, register 0 reads 0x48 and register 1 reads 0xA0. The CPU clock enable then pulses once every 8 fast cycles: the eighth running cycle after reset release, and every eighth cycle after that.
- R2: The main-clock divide ratio is set by two fields:
  - register 0 bit 6 = 0 gives divide by 1;
  - otherwise register 1 bits 7:6 choose it: 00 = /2, 01 = /4, 10 = /8, 11 = /16.
- R3: A new source or ratio takes effect only in the cycle after a CPU clock pulse, and the divider then restarts from zero. If the clock currently feeding the CPU is halted, the change takes effect at the next edge.
- R4: With register 0 bit 7 set, the CPU clock enable equals the sub-clock enable.
- R5: A write that sets register 0 bit 7 is ignored while bit 4 is 0. A write that clears bit 4 is ignored while bit 7 is 1.
- R6: Register 0 bit 5 = 1 halts the main clock. The three peripheral enables stay low, the main-sourced CPU clock stops, and the peripheral prescaler holds its count.
- R7: The prescaler advances on every cycle in which the main clock runs.
  - The divide-by-1 peripheral enable is high on every running cycle.
  - The divide-by-8 enable is high when the prescaler's low three bits are 7.
  - The divide-by-32 enable is high when the prescaler's five-bit count is 31.
- R8: With wait mode high and register 0 bit 2 = 1, the three peripheral enables are low. With bit 2 = 0, wait mode has no effect on them.
- R9: The sub-clock enable is a one-cycle pulse. It is high in the cycle after the second synchroniser flop first captures a high level of the sub-oscillator input. It pulses only while register 0 bit 4 is 1 and stop mode is low.
- R10: The divided sub-clock enable is high on every 32nd sub-clock enable pulse: the 32nd, 64th, and so on.
- R11: Entering stop mode (a rising edge of the stop input) from main-clock operation (bit 7 = 0) forces three bits to 1: register 0 bit 6, register 1 bit 5 and register 0 bit 3. These take priority over a write in the same cycle.
- R12: Entering stop mode from sub-clock operation (bit 7 = 1) forces only register 0 bit 3 to 1. Register 0 bit 6 and register 1 bit 5 keep their values.
- R13: While stop mode is high, every enable output is low.
- R14: Writes take effect at the next edge. Address 0 writes register 0 bits 7:2; address 1 writes register 1 bits 7:5. All other bits read 0.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast main-oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | Register select: 0 or 1 |
| wrData | input | 8 | Register write data |
| subOsc | input | 1 | Raw sub-oscillator level, asynchronous |
| stopMode | input | 1 | Stop mode active |
| waitActive | input | 1 | Wait instruction in progress |
| bclkEn | output | 1 | CPU bus clock enable |
| f1En | output | 1 | Peripheral enable, main /1 |
| f8En | output | 1 | Peripheral enable, main /8 |
| f32En | output | 1 | Peripheral enable, main /32 |
| fcEn | output | 1 | Sub-clock enable |
| fc32En | output | 1 | Sub-clock /32 enable |
| ctrl0Rd | output | 8 | Register 0 contents |
| ctrl1Rd | output | 8 | Register 1 contents |

## Verification

The bench changes the divide ratio at arbitrary points within a divided period. A design that switched at once would emit a short bus-clock period, which shows up as a pulse earlier than the reference model predicts.

The bench then tests the register guards:

- It tries to select the sub-clock before the sub-oscillator is started. A design without the guard would move the CPU onto a dead clock.
- It tries to stop the sub-oscillator while it feeds the CPU.

It enters stop mode once from each speed mode after clearing the affected bits. A design that ignored the speed mode would either fail to restore the divide and drive bits, or clobber them wrongly. Wait gating is applied both armed and unarmed, which catches a design that gates unconditionally.

// File: rtl/clkCtrlPkg.sv
package clkCtrlPkg;

  localparam int REG_W   = 8;
  localparam int SHIFT_W = 3;

  // register 0 field positions
  localparam int C0_WAIT    = 2;
  localparam int C0_SUBDRV  = 3;
  localparam int C0_SUBON   = 4;
  localparam int C0_MAINOFF = 5;
  localparam int C0_DIV0    = 6;
  localparam int C0_SYSSEL  = 7;

  // register 1 field positions
  localparam int C1_MAINDRV = 5;
  localparam int C1_DIVLO   = 6;
  localparam int C1_DIVHI   = 7;

  // strobes from control to datapath
  typedef struct packed {
    logic               mainRun;
    logic               subRun;
    logic               perGate;
    logic               srcSub;
    logic [SHIFT_W-1:0] shift;
  } ctrlStrobe_t;

endpackage

// File: rtl/clkCtrlRegs.sv
module clkCtrlRegs
  import clkCtrlPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [REG_W-1:0] wrData,
  input  logic             stopMode,
  input  logic             waitActive,
  output ctrlStrobe_t      strobe,
  output logic [REG_W-1:0] ctrl0Rd,
  output logic [REG_W-1:0] ctrl1Rd
);

  logic       waitPerStop;
  logic       subDrive;
  logic       subStart;
  logic       mainStop;
  logic       div0;
  logic       sysSel;
  logic       mainDrive;
  logic [1:0] divSel;
  logic       stopQ;
  logic       stopEntry;
  logic       wr0;
  logic       wr1;

  assign stopEntry = stopMode & ~stopQ;
  assign wr0       = wrEn & ~wrAddr;
  assign wr1       = wrEn & wrAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitPerStop <= 1'b0;
      subDrive    <= 1'b1;
      subStart    <= 1'b0;
      mainStop    <= 1'b0;
      div0        <= 1'b1;
      sysSel      <= 1'b0;
      mainDrive   <= 1'b1;
      divSel      <= 2'b10;
      stopQ       <= 1'b0;
    end else begin
      stopQ <= stopMode;
      if (wr0) begin
        waitPerStop <= wrData[C0_WAIT];
        subDrive    <= wrData[C0_SUBDRV];
        // sub-oscillator cannot be stopped while it feeds the CPU
        subStart    <= wrData[C0_SUBON] | sysSel;
        mainStop    <= wrData[C0_MAINOFF];
        div0        <= wrData[C0_DIV0];
        // sub-clock selectable only once it has been started
        sysSel      <= wrData[C0_SYSSEL] & subStart;
      end
      if (wr1) begin
        mainDrive <= wrData[C1_MAINDRV];
        divSel    <= wrData[C1_DIVHI:C1_DIVLO];
      end
      if (stopEntry) begin
        subDrive <= 1'b1;
        if (!sysSel) begin
          div0      <= 1'b1;
          mainDrive <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.mainRun = ~mainStop & ~stopMode;
    strobe.subRun  = subStart & ~stopMode;
    strobe.perGate = waitActive & waitPerStop;
    strobe.srcSub  = sysSel;
    strobe.shift   = div0 ? (SHIFT_W'({1'b0, divSel}) + SHIFT_W'(1)) : '0;
  end

  always_comb begin
    ctrl0Rd              = '0;
    ctrl0Rd[C0_WAIT]     = waitPerStop;
    ctrl0Rd[C0_SUBDRV]   = subDrive;
    ctrl0Rd[C0_SUBON]    = subStart;
    ctrl0Rd[C0_MAINOFF]  = mainStop;
    ctrl0Rd[C0_DIV0]     = div0;
    ctrl0Rd[C0_SYSSEL]   = sysSel;
    ctrl1Rd              = '0;
    ctrl1Rd[C1_MAINDRV]  = mainDrive;
    ctrl1Rd[C1_DIVHI:C1_DIVLO] = divSel;
  end

endmodule

// File: rtl/clkCtrlDatapath.sv
module clkCtrlDatapath
  import clkCtrlPkg::*;
#(
  parameter int PRE_W       = 5,
  parameter int F8_LOG2     = 3,
  parameter int FC_LOG2     = 5,
  parameter int SYNC_STAGES = 2,
  parameter int BCNT_W      = 4,
  parameter int RESET_SHIFT = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        subOsc,
  input  ctrlStrobe_t strobe,
  output logic        bclkEn,
  output logic        f1En,
  output logic        f8En,
  output logic        f32En,
  output logic        fcEn,
  output logic        fc32En
);

  localparam logic [PRE_W-1:0]   PRE_LAST = '1;
  localparam logic [F8_LOG2-1:0] F8_LAST  = '1;
  localparam logic [FC_LOG2-1:0] FC_LAST  = '1;

  logic [PRE_W-1:0]       preCnt;
  logic [BCNT_W-1:0]      bclkCnt;
  logic [BCNT_W-1:0]      bclkLast;
  logic [FC_LOG2-1:0]     fcCnt;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   edgeQ;
  logic                   activeSubQ;
  logic [SHIFT_W-1:0]     activeShift;
  logic                   mainTick;
  logic                   subPulse;
  logic                   halted;
  logic                   cfgLoad;

  // sub-oscillator synchroniser chain
  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : gSync
      if (i == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[i] <= 1'b0;
          else       syncQ[i] <= subOsc;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[i] <= 1'b0;
          else       syncQ[i] <= syncQ[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeQ <= 1'b0;
    else       edgeQ <= syncQ[SYNC_STAGES-1];
  end

  assign subPulse = strobe.subRun & syncQ[SYNC_STAGES-1] & ~edgeQ;
  assign bclkLast = BCNT_W'((32'd1 << activeShift) - 32'd1);
  assign mainTick = strobe.mainRun & (bclkCnt == bclkLast);

  assign bclkEn = activeSubQ ? subPulse : mainTick;
  assign f1En   = strobe.mainRun & ~strobe.perGate;
  assign f8En   = f1En & (preCnt[F8_LOG2-1:0] == F8_LAST);
  assign f32En  = f1En & (preCnt == PRE_LAST);
  assign fcEn   = subPulse;
  assign fc32En = subPulse & (fcCnt == FC_LAST);

  // switch on a boundary of the current clock, or at once if it is halted
  assign halted  = activeSubQ ? ~strobe.subRun : ~strobe.mainRun;
  assign cfgLoad = bclkEn | halted;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt      <= '0;
      bclkCnt     <= '0;
      fcCnt       <= '0;
      activeSubQ  <= 1'b0;
      activeShift <= SHIFT_W'(RESET_SHIFT);
    end else begin
      if (strobe.mainRun) preCnt <= preCnt + 1'b1;
      if (cfgLoad || mainTick)  bclkCnt <= '0;
      else if (strobe.mainRun)  bclkCnt <= bclkCnt + 1'b1;
      if (subPulse) fcCnt <= fcCnt + 1'b1;
      if (cfgLoad) begin
        activeSubQ  <= strobe.srcSub;
        activeShift <= strobe.shift;
      end
    end
  end

endmodule

// File: rtl/clkCtrlUnit.sv
module clkCtrlUnit
  import clkCtrlPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrAddr,
  input  logic [7:0] wrData,
  input  logic       subOsc,
  input  logic       stopMode,
  input  logic       waitActive,
  output logic       bclkEn,
  output logic       f1En,
  output logic       f8En,
  output logic       f32En,
  output logic       fcEn,
  output logic       fc32En,
  output logic [7:0] ctrl0Rd,
  output logic [7:0] ctrl1Rd
);

  ctrlStrobe_t strobe;

  clkCtrlRegs uRegs (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .stopMode   (stopMode),
    .waitActive (waitActive),
    .strobe     (strobe),
    .ctrl0Rd    (ctrl0Rd),
    .ctrl1Rd    (ctrl1Rd)
  );

  clkCtrlDatapath #(
    .PRE_W       (5),
    .F8_LOG2     (3),
    .FC_LOG2     (5),
    .SYNC_STAGES (2),
    .BCNT_W      (4),
    .RESET_SHIFT (3)
  ) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .subOsc (subOsc),
    .strobe (strobe),
    .bclkEn (bclkEn),
    .f1En   (f1En),
    .f8En   (f8En),
    .f32En  (f32En),
    .fcEn   (fcEn),
    .fc32En (fc32En)
  );

endmodule

// File: rtl/clkCtrlChecker.sv
module clkCtrlChecker (
  input logic       clk,
  input logic       rstN,
  input logic       stopMode,
  input logic       waitActive,
  input logic       bclkEn,
  input logic       f1En,
  input logic       f8En,
  input logic       f32En,
  input logic       fcEn,
  input logic       fc32En,
  input logic [7:0] ctrl0Rd,
  input logic [7:0] ctrl1Rd
);

  assert_stop_quiet_R13: assert property (@(posedge clk) disable iff (!rstN)
    stopMode |-> !(bclkEn || f1En || f8En || f32En || fcEn || fc32En));

  assert_f8_in_f1_R7: assert property (@(posedge clk) disable iff (!rstN)
    f8En |-> f1En);

  assert_f32_in_f8_R7: assert property (@(posedge clk) disable iff (!rstN)
    f32En |-> f8En);

  assert_fc32_in_fc_R10: assert property (@(posedge clk) disable iff (!rstN)
    fc32En |-> fcEn);

  assert_main_halt_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl0Rd[5] |-> !(f1En || f8En || f32En));

  assert_wait_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (waitActive && ctrl0Rd[2]) |-> !f1En);

  assert_sel_guard_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrl0Rd[7]) |-> $past(ctrl0Rd[4]));

  assert_stop_subdrv_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopMode) |=> ctrl0Rd[3]);

  assert_fc_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    fcEn |=> !fcEn);

  assert_unused_bits_R14: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl0Rd[1:0] == 2'b00) && (ctrl1Rd[4:0] == 5'b00000));

endmodule

bind clkCtrlUnit clkCtrlChecker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .stopMode   (stopMode),
  .waitActive (waitActive),
  .bclkEn     (bclkEn),
  .f1En       (f1En),
  .f8En       (f8En),
  .f32En      (f32En),
  .fcEn       (fcEn),
  .fc32En     (fc32En),
  .ctrl0Rd    (ctrl0Rd),
  .ctrl1Rd    (ctrl1Rd)
);

// File: tb/tb_clkCtrlUnit.sv
module tb_clkCtrlUnit;

  localparam time CLK_PERIOD = 10ns;
  localparam int  SUB_HALF   = 5;
  localparam int  WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrAddr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       subOsc = 1'b0;
  logic       stopMode = 1'b0;
  logic       waitActive = 1'b0;
  logic       bclkEn, f1En, f8En, f32En, fcEn, fc32En;
  logic [7:0] ctrl0Rd, ctrl1Rd;

  int  vectors = 0;
  int  miscompares = 0;
  bit  checking = 1'b0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkCtrlUnit dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .subOsc(subOsc), .stopMode(stopMode), .waitActive(waitActive),
    .bclkEn(bclkEn), .f1En(f1En), .f8En(f8En), .f32En(f32En),
    .fcEn(fcEn), .fc32En(fc32En), .ctrl0Rd(ctrl0Rd), .ctrl1Rd(ctrl1Rd)
  );

  // behavioural reference state
  bit       mWait, mSubDrv, mSubOn, mMainOff, mDiv0, mSysSel, mMainDrv, mStopQ;
  bit [1:0] mDivSel;
  int       mPre, mBcnt, mFc, mActDiv;
  bit       mActSub;
  bit       s1, s2, s3;

  function automatic bit expMainRun();
    return !mMainOff && !stopMode;
  endfunction
  function automatic bit expSubRun();
    return mSubOn && !stopMode;
  endfunction
  function automatic bit expFc();
    return expSubRun() && s2 && !s3;
  endfunction
  function automatic bit expTick();
    return expMainRun() && (mBcnt == mActDiv - 1);
  endfunction
  function automatic bit expBclk();
    return mActSub ? expFc() : expTick();
  endfunction
  function automatic bit expF1();
    return expMainRun() && !(waitActive && mWait);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // model update on every edge
  always @(posedge clk) begin
    if (!rstN) begin
      mWait = 0; mSubDrv = 1; mSubOn = 0; mMainOff = 0; mDiv0 = 1; mSysSel = 0;
      mMainDrv = 1; mDivSel = 2'b10; mStopQ = 0;
      mPre = 0; mBcnt = 0; mFc = 0; mActDiv = 8; mActSub = 0;
      s1 = 0; s2 = 0; s3 = 0;
    end else begin
      bit mainRun, fc, tick, bclk, halted, load, oldSel, oldOn, entry;
      int reqDiv;
      mainRun = expMainRun();
      fc      = expFc();
      tick    = expTick();
      bclk    = expBclk();
      halted  = mActSub ? !expSubRun() : !mainRun;
      load    = bclk || halted;
      reqDiv  = mDiv0 ? (2 << mDivSel) : 1;
      if (mainRun) mPre = (mPre + 1) % 32;
      if (load || tick) mBcnt = 0;
      else if (mainRun) mBcnt++;
      if (load) begin mActSub = mSysSel; mActDiv = reqDiv; end
      if (fc) mFc = (mFc + 1) % 32;
      s3 = s2; s2 = s1; s1 = subOsc;
      oldSel = mSysSel; oldOn = mSubOn;
      entry  = stopMode && !mStopQ;
      mStopQ = stopMode;
      if (wrEn && !wrAddr) begin
        mWait = wrData[2]; mSubDrv = wrData[3]; mSubOn = wrData[4] || oldSel;
        mMainOff = wrData[5]; mDiv0 = wrData[6]; mSysSel = wrData[7] && oldOn;
      end
      if (wrEn && wrAddr) begin
        mMainDrv = wrData[5]; mDivSel = wrData[7:6];
      end
      if (entry) begin
        mSubDrv = 1;
        if (!oldSel) begin mDiv0 = 1; mMainDrv = 1; end
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (checking && !done) begin
      chk("R1/R2/R3/R4 bclkEn", bclkEn, expBclk());
      chk("R7/R8 f1En", f1En, expF1());
      chk("R7 f8En", f8En, expF1() && (mPre % 8 == 7));
      chk("R7 f32En", f32En, expF1() && (mPre == 31));
      chk("R9 fcEn", fcEn, expFc());
      chk("R10 fc32En", fc32En, expFc() && (mFc == 31));
      chk("R14 ctrl0Rd", ctrl0Rd,
          {mSysSel, mDiv0, mMainOff, mSubOn, mSubDrv, mWait, 2'b00});
      chk("R14 ctrl1Rd", ctrl1Rd, {mDivSel, mMainDrv, 5'b00000});
    end
  end

  // free-running sub-oscillator
  initial begin
    forever begin
      repeat (SUB_HALF) @(posedge clk);
      #1 subOsc = ~subOsc;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wr(input bit addr, input logic [7:0] data);
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = addr; wrData = data;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic setStop(input bit v);
    @(posedge clk); #1 stopMode = v;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    checking = 1'b1;
    @(negedge clk);
    chk("R1 reset ctrl0", ctrl0Rd, 8'h48);
    chk("R1 reset ctrl1", ctrl1Rd, 8'hA0);
    idle(40);                       // R1 divide by 8
    wr(0, 8'h08); idle(30);         // R2 divide by 1, R3 boundary switch
    wr(0, 8'h48); wr(1, 8'h20); idle(20);  // R2 /2
    wr(1, 8'h60); idle(30);                // R2 /4
    wr(1, 8'hE0); idle(5); wr(1, 8'h20); idle(60); // R3 mid-period change
    wr(1, 8'hE0); idle(60);                // R2 /16
    wr(0, 8'hC8); @(negedge clk);
    chk("R5 select ignored", ctrl0Rd[7], 0);
    wr(0, 8'h58); idle(30);         // start sub-oscillator
    wr(0, 8'hD8); idle(80);         // R4 CPU on sub-clock
    @(negedge clk);
    chk("R4 source selected", ctrl0Rd[7], 1);
    wr(0, 8'hC8); @(negedge clk);
    chk("R5 stop ignored", ctrl0Rd[4], 1);
    wr(0, 8'hF8); idle(40);         // R6 main clock halted
    @(negedge clk);
    chk("R6 f1 halted", f1En, 0);
    wr(0, 8'h90); wr(1, 8'h00);
    setStop(1'b1); idle(20);        // R12 stop from sub-clock
    @(negedge clk);
    chk("R13 bclk quiet", bclkEn, 0);
    chk("R12 subdrv forced", ctrl0Rd[3], 1);
    chk("R12 div0 kept", ctrl0Rd[6], 0);
    chk("R12 maindrv kept", ctrl1Rd[5], 0);
    setStop(1'b0);
    wr(0, 8'h10); idle(40);         // back to main /1
    wr(0, 8'h14); #1 waitActive = 1'b1; idle(20);
    @(negedge clk);
    chk("R8 gated", f1En, 0);
    wr(0, 8'h10); idle(20);
    @(negedge clk);
    chk("R8 not armed", f1En, 1);
    #1 waitActive = 1'b0;
    wr(0, 8'h10); wr(1, 8'h00);
    setStop(1'b1); idle(10);        // R11 stop from main clock
    @(negedge clk);
    chk("R11 div0 forced", ctrl0Rd[6], 1);
    chk("R11 maindrv forced", ctrl1Rd[5], 1);
    chk("R11 subdrv forced", ctrl0Rd[3], 1);
    setStop(1'b0);
    idle(400);                      // R10 several fc32 pulses
    @(negedge clk);
    finishRun();
  end

endmodule